// File: doc/BRIEF.md
# Multi-game cartridge bank controller

This controller sits on the cartridge side of a handheld console flash cart that holds many games in one large NOR flash. After power-on a loader menu runs from the flash and talks to the controller with plain CPU writes. Writes are seen as the upper address nibble (A15..A12), the data byte and an active-low write strobe. During the loader phase the menu writes the chosen game's base region. A second write then commits that choice and starts a stretched, active-high pulse, which drives an external N-channel transistor that holds the console in reset.

The commit also locks the controller. From then on the loader writes are ignored and the block works as an MBC5-style mapper. It has a 9-bit ROM bank, a 4-bit RAM bank and a RAM enable. The flash bank output is the running game's bank plus the locked base region, so each game sees its own slice of the flash as if it owned the whole cart.

Top module: `mgc_cart_ctrl`

## Requirements
- R1: When rst_n is low at a clock edge, the block returns to the select stage. It sets base region 0, ROM bank 1, RAM bank 0 and RAM enable 0, and releases console_rst (0).
- R2: A write takes effect only at the first clock edge where cpu_wr_n is sampled high after being sampled low. It uses the nibble and data sampled at the edge before. While cpu_wr_n stays low, nothing changes.
- R3: In the select stage, a write to nibble 6 (0x6000-0x6FFF) loads the data byte into the base region register. A later nibble-6 write replaces it.
- R4: In the select stage, a write to nibble 5 (0x5000-0x5FFF) raises console_rst. It also sets the ROM bank to 1, clears the RAM bank to 0 and moves the block to the locked stage.
- R5: A write to nibble 7 (0x7000-0x7FFF) never triggers a reset and never changes the base region.
- R6: In the locked stage, nibble-6 and nibble-5 writes no longer change the base region or raise console_rst. A nibble-5 write then acts as a RAM bank write.
- R7: console_rst stays high for exactly RST_CYCLES clock cycles (default 1024) per trigger and then returns low.
- R8: A nibble-2 write sets ROM bank bits 7:0 to the data byte. A nibble-3 write sets ROM bank bit 8 to data bit 0. Bank 0 is kept as 0 and is not remapped to 1.
- R9: A nibble-4 write sets the RAM bank to data bits 3:0. A write to nibble 0 or 1 sets ram_en to 1 when data bits 3:0 equal 0xA, and to 0 otherwise.
- R10: flash_bank = (base << 4) + (cpu_addr_hi[2] ? ROM bank : 0), taken modulo 2^12. The output follows cpu_addr_hi in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cpu_addr_hi | input | 4 | CPU address bits 15..12 |
| cpu_data | input | 8 | CPU data byte |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| flash_bank | output | 12 | Flash address bits above the 16 KB window |
| ram_bank | output | 4 | External RAM bank |
| ram_en | output | 1 | External RAM access enable |
| console_rst | output | 1 | Active-high drive to the console-reset transistor |

## Verification
All register results are due at the first falling clock edge after the clock edge that samples cpu_wr_n high. The bench's write task raises the strobe on a falling edge and returns exactly one falling edge later, so each check lands there. flash_bank has no register of its own: the bench changes cpu_addr_hi and checks 1 ns later. The reset width is counted on falling edges, from the first high sample to the last. Checks made while the strobe is still held low show that nothing moves before the rising edge.

// File: rtl/mgc_pkg.sv
// Package: shared widths, stage encoding, address-nibble decodes and the
// write-event record passed from the bus sampler to the register blocks.
package mgc_pkg;

    localparam int NIB_W  = 4;
    localparam int DATA_W = 8;

    // Loader stage, kept in two bits; value 0 and 3 are never entered.
    typedef enum logic [1:0] {
        STG_IDLE   = 2'd0,
        STG_SELECT = 2'd1,
        STG_LOCKED = 2'd2,
        STG_SPARE  = 2'd3
    } stage_e;

    // Upper-nibble decodes of the CPU address.
    localparam logic [NIB_W-1:0] NIB_RAMEN_A = 4'h0;
    localparam logic [NIB_W-1:0] NIB_RAMEN_B = 4'h1;
    localparam logic [NIB_W-1:0] NIB_ROM_LO  = 4'h2;
    localparam logic [NIB_W-1:0] NIB_ROM_HI  = 4'h3;
    localparam logic [NIB_W-1:0] NIB_RAMBANK = 4'h4;
    localparam logic [NIB_W-1:0] NIB_COMMIT  = 4'h5;
    localparam logic [NIB_W-1:0] NIB_BASE    = 4'h6;

    localparam logic [3:0] RAM_KEY = 4'hA;

    // One completed CPU write.
    typedef struct packed {
        logic              valid;
        logic [NIB_W-1:0]  nib;
        logic [DATA_W-1:0] data;
    } wr_evt_t;

endpackage

// File: rtl/mgc_bus_sampler.sv
// Module: mgc_bus_sampler
// Turns the raw CPU strobe into a one-cycle write event. Address nibble and
// data are registered every cycle. The event fires when the strobe is first
// seen high after a low sample and carries the values registered one cycle
// earlier, so late-settling bus drivers are tolerated.
// Assumes: cpu_wr_n is already synchronous to clk (slow bus, no metastability
// handling here); synchronous active-low reset.
module mgc_bus_sampler
    import mgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  addr_hi,
    input  logic [DATA_W-1:0] data,
    input  logic              wr_n,
    output wr_evt_t           evt
);

    logic              wr_q;
    logic [NIB_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: one-cycle history of strobe, address nibble and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b1;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            wr_q   <= wr_n;
            addr_q <= addr_hi;
            data_q <= data;
        end
    end

    // Purpose: rising strobe edge qualifies the held address/data as a write.
    always_comb begin
        evt.valid = wr_n & ~wr_q;
        evt.nib   = addr_q;
        evt.data  = data_q;
    end

endmodule

// File: rtl/mgc_loader_seq.sv
// Module: mgc_loader_seq
// Loader stage machine. In the select stage a nibble-6 write loads the game
// base region and a nibble-5 write commits it, fires the reset trigger and
// locks the stage. Nibble 7 is deliberately not a trigger. Once locked,
// nothing here changes until power-on reset.
// Assumes: evt.valid is a single-cycle pulse.
module mgc_loader_seq
    import mgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_evt_t           evt,
    output stage_e            stage,
    output logic [DATA_W-1:0] base,
    output logic              trigger
);

    stage_e            stage_q;
    logic [DATA_W-1:0] base_q;
    logic              in_select;

    assign in_select = (stage_q == STG_SELECT);

    // Purpose: commit request from a nibble-5 write in the select stage.
    always_comb begin
        trigger = evt.valid && in_select && (evt.nib == NIB_COMMIT);
    end

    // Purpose: stage progression select -> locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= STG_SELECT;
        end else if (trigger) begin
            stage_q <= STG_LOCKED;
        end
    end

    // Purpose: capture the base region while still selecting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (evt.valid && in_select && (evt.nib == NIB_BASE)) begin
            base_q <= evt.data;
        end
    end

    assign stage = stage_q;
    assign base  = base_q;

endmodule

// File: rtl/mgc_mbc5_regs.sv
// Module: mgc_mbc5_regs
// MBC5-style bank registers: 9-bit ROM bank split over two write windows,
// RAM bank and RAM enable. The commit trigger forces ROM bank 1 and RAM
// bank 0. The nibble-5 window is a RAM-bank alias only once locked, because
// in the select stage it is the commit trigger.
// Assumes: 9 <= ROM_BANK_W <= 16, RAM_BANK_W <= 8.
module mgc_mbc5_regs
    import mgc_pkg::*;
#(
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_evt_t               evt,
    input  stage_e                stage,
    input  logic                  trigger,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en
);

    localparam int ROM_HI_W = ROM_BANK_W - DATA_W;

    logic [ROM_BANK_W-1:0] rom_q;
    logic [RAM_BANK_W-1:0] ram_q;
    logic                  en_q;
    logic                  ram_win;
    logic                  en_win;

    // Purpose: decode the RAM-bank window (nibble 5 only when locked).
    always_comb begin
        ram_win = evt.valid && ((evt.nib == NIB_RAMBANK) ||
                  ((evt.nib == NIB_COMMIT) && (stage == STG_LOCKED)));
        en_win  = evt.valid && ((evt.nib == NIB_RAMEN_A) ||
                  (evt.nib == NIB_RAMEN_B));
    end

    // Purpose: ROM bank register, forced to 1 by the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_q <= ROM_BANK_W'(1);
        end else if (trigger) begin
            rom_q <= ROM_BANK_W'(1);
        end else if (evt.valid && evt.nib == NIB_ROM_LO) begin
            rom_q[DATA_W-1:0] <= evt.data;
        end else if (evt.valid && evt.nib == NIB_ROM_HI) begin
            rom_q[ROM_BANK_W-1:DATA_W] <= evt.data[ROM_HI_W-1:0];
        end
    end

    // Purpose: RAM bank register, cleared by the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_q <= '0;
        end else if (trigger) begin
            ram_q <= '0;
        end else if (ram_win) begin
            ram_q <= evt.data[RAM_BANK_W-1:0];
        end
    end

    // Purpose: RAM enable, set only by the key value in the low nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_win) begin
            en_q <= (evt.data[3:0] == RAM_KEY);
        end
    end

    assign rom_bank = rom_q;
    assign ram_bank = ram_q;
    assign ram_en   = en_q;

endmodule

// File: rtl/mgc_reset_pulse.sv
// Module: mgc_reset_pulse
// Stretches the one-cycle commit trigger into a console reset of exactly
// RST_CYCLES clocks. The state is an active-low register; the output to
// the transistor gate is its inverse, so idle and reset both give 0.
// Assumes: RST_CYCLES >= 2; trigger cannot recur while a pulse runs.
module mgc_reset_pulse #(
    parameter int RST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic console_rst
);

    localparam int CNT_W = $clog2(RST_CYCLES);

    logic             drv_n_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: load the width counter on trigger, release when it empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_n_q <= 1'b1;
            cnt_q   <= '0;
        end else if (trigger) begin
            drv_n_q <= 1'b0;
            cnt_q   <= CNT_W'(RST_CYCLES - 1);
        end else if (!drv_n_q) begin
            if (cnt_q == '0) begin
                drv_n_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign console_rst = ~drv_n_q;

endmodule

// File: rtl/mgc_addr_map.sv
// Module: mgc_addr_map
// Forms the flash bank: the base region scaled by 2^BASE_SHIFT banks plus
// the ROM bank in the switchable window (A14 high), or plus 0 in the fixed
// window. The sum wraps at FLASH_BANK_W bits. Purely combinational.
// Assumes: BASE_W + BASE_SHIFT <= FLASH_BANK_W.
module mgc_addr_map #(
    parameter int BASE_W       = 8,
    parameter int BASE_SHIFT   = 4,
    parameter int ROM_BANK_W   = 9,
    parameter int FLASH_BANK_W = 12
) (
    input  logic [BASE_W-1:0]       base,
    input  logic [ROM_BANK_W-1:0]   rom_bank,
    input  logic                    upper_win,
    output logic [FLASH_BANK_W-1:0] flash_bank
);

    logic [FLASH_BANK_W-1:0] base_ext;
    logic [FLASH_BANK_W-1:0] off_ext;

    // Purpose: scale the base region; the shift-free variant avoids a
    // zero-width pad.
    generate
        if (BASE_SHIFT == 0) begin : g_noshift
            assign base_ext = FLASH_BANK_W'(base);
        end else begin : g_shift
            assign base_ext = FLASH_BANK_W'({base, {BASE_SHIFT{1'b0}}});
        end
    endgenerate

    // Purpose: window offset and the wrapping sum.
    always_comb begin
        off_ext    = upper_win ? FLASH_BANK_W'(rom_bank) : '0;
        flash_bank = base_ext + off_ext;
    end

endmodule

// File: rtl/mgc_cart_ctrl.sv
// Module: mgc_cart_ctrl (top)
// Multi-game cartridge controller: bus sampler, loader stage machine,
// MBC5-style registers, reset stretcher and flash bank adder.
// Assumes: a single clock, synchronous active-low power-on reset, CPU bus
// signals already in the clk domain at the logic levels of this device.
module mgc_cart_ctrl
    import mgc_pkg::*;
#(
    parameter int RST_CYCLES   = 1024,
    parameter int BASE_SHIFT   = 4,
    parameter int ROM_BANK_W   = 9,
    parameter int RAM_BANK_W   = 4,
    parameter int FLASH_BANK_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              cpu_addr_hi,
    input  logic [7:0]              cpu_data,
    input  logic                    cpu_wr_n,
    output logic [FLASH_BANK_W-1:0] flash_bank,
    output logic [RAM_BANK_W-1:0]   ram_bank,
    output logic                    ram_en,
    output logic                    console_rst
);

    wr_evt_t               evt_w;
    stage_e                stage_w;
    logic [DATA_W-1:0]     base_w;
    logic                  trigger_w;
    logic [ROM_BANK_W-1:0] rom_bank_w;

    mgc_bus_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (cpu_addr_hi),
        .data    (cpu_data),
        .wr_n    (cpu_wr_n),
        .evt     (evt_w)
    );

    mgc_loader_seq u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_w),
        .stage   (stage_w),
        .base    (base_w),
        .trigger (trigger_w)
    );

    mgc_mbc5_regs #(
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_mbc (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_w),
        .stage    (stage_w),
        .trigger  (trigger_w),
        .rom_bank (rom_bank_w),
        .ram_bank (ram_bank),
        .ram_en   (ram_en)
    );

    mgc_reset_pulse #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger_w),
        .console_rst (console_rst)
    );

    mgc_addr_map #(
        .BASE_W       (DATA_W),
        .BASE_SHIFT   (BASE_SHIFT),
        .ROM_BANK_W   (ROM_BANK_W),
        .FLASH_BANK_W (FLASH_BANK_W)
    ) u_map (
        .base       (base_w),
        .rom_bank   (rom_bank_w),
        .upper_win  (cpu_addr_hi[2]),
        .flash_bank (flash_bank)
    );

endmodule

// File: rtl/mgc_cart_ctrl_chk.sv
// Module: mgc_cart_ctrl_chk
// Temporal checks on the controller, bound into every mgc_cart_ctrl.
// Assumes: rst_n is driven low from time zero by the environment.
module mgc_cart_ctrl_chk
    import mgc_pkg::*;
#(
    parameter int RST_CYCLES = 1024,
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  console_rst,
    input stage_e                stage,
    input logic [DATA_W-1:0]     base_bank,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [RAM_BANK_W-1:0] ram_bank
);

    localparam int HW = $clog2(RST_CYCLES) + 2;

    logic [HW-1:0] hi_cnt;

    // Purpose: count consecutive cycles with the reset drive high.
    always_ff @(posedge clk) begin
        if (!rst_n || !console_rst) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + HW'(1);
        end
    end

    p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(console_rst) |-> (hi_cnt == HW'(RST_CYCLES)));

    p_rise_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(console_rst) |-> (stage == STG_LOCKED && $past(stage) == STG_SELECT));

    p_rise_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(console_rst) |-> (rom_bank == ROM_BANK_W'(1) && ram_bank == '0));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == STG_LOCKED) |=> (stage == STG_LOCKED));

    p_base_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == STG_LOCKED) |=> $stable(base_bank));

    p_stage_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == STG_SELECT) || (stage == STG_LOCKED));

endmodule

bind mgc_cart_ctrl mgc_cart_ctrl_chk #(
    .RST_CYCLES (RST_CYCLES),
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .console_rst (console_rst),
    .stage       (stage_w),
    .base_bank   (base_w),
    .rom_bank    (rom_bank_w),
    .ram_bank    (ram_bank)
);

// File: tb/mgc_cart_ctrl_tb_top.sv
// Directed bench for mgc_cart_ctrl: one task per scenario, each checking
// its own results at falling clock edges.
module mgc_cart_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_addr_hi = 4'h0;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr_n = 1'b1;
    logic [11:0] flash_bank;
    logic [3:0]  ram_bank;
    logic        ram_en;
    logic        console_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mgc_cart_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr_hi (cpu_addr_hi),
        .cpu_data    (cpu_data),
        .cpu_wr_n    (cpu_wr_n),
        .flash_bank  (flash_bank),
        .ram_bank    (ram_bank),
        .ram_en      (ram_en),
        .console_rst (console_rst)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] nib, input logic [7:0] dat);
        @(negedge clk);
        cpu_addr_hi = nib;
        cpu_data    = dat;
        cpu_wr_n    = 1'b0;
        repeat (2) @(negedge clk);
        cpu_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic look(input logic [3:0] nib);
        cpu_addr_hi = nib;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1", "console_rst", console_rst, 0);
        check("R1", "ram_bank", ram_bank, 0);
        check("R1", "ram_en", ram_en, 0);
        look(4'h0); check("R1", "flash fixed window", flash_bank, 0);
        look(4'h4); check("R1", "flash rom bank 1", flash_bank, 1);
    endtask

    task automatic t_select_base();
        bus_write(4'h6, 8'h05);
        look(4'h0); check("R3", "base 5 fixed", flash_bank, 80);
        look(4'h4); check("R10", "base 5 + rom 1", flash_bank, 81);
        bus_write(4'h6, 8'h02);
        look(4'h0); check("R3", "base rewritten", flash_bank, 32);
    endtask

    task automatic t_strobe_timing();
        @(negedge clk);
        cpu_addr_hi = 4'h6; cpu_data = 8'h03; cpu_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2", "no change while strobe low", flash_bank, 33);
        cpu_wr_n = 1'b1; cpu_addr_hi = 4'h7; cpu_data = 8'hFF;
        @(negedge clk);
        check("R2", "old nibble/data used at strobe rise", flash_bank, 49);
        check("R5", "nibble 7 at rise no reset", console_rst, 0);
    endtask

    task automatic t_ignore_seven();
        bus_write(4'h7, 8'h0A);
        repeat (3) @(negedge clk);
        check("R5", "nibble 7 no reset", console_rst, 0);
        look(4'h0); check("R5", "nibble 7 base kept", flash_bank, 48);
    endtask

    task automatic t_mbc_select();
        bus_write(4'h2, 8'h10);
        look(4'h4); check("R8", "rom low 0x10", flash_bank, 64);
        bus_write(4'h3, 8'h01);
        look(4'h4); check("R8", "rom bit8 set", flash_bank, 320);
        bus_write(4'h2, 8'h00);
        bus_write(4'h3, 8'h00);
        look(4'h4); check("R8", "rom bank 0 kept", flash_bank, 48);
        bus_write(4'h4, 8'hFB);
        check("R9", "ram bank low nibble", ram_bank, 11);
        bus_write(4'h0, 8'h0A);
        check("R9", "ram enable key", ram_en, 1);
        bus_write(4'h1, 8'h1A);
        check("R9", "ram enable alias", ram_en, 1);
        bus_write(4'h0, 8'h00);
        check("R9", "ram disable", ram_en, 0);
        bus_write(4'h2, 8'h07);
    endtask

    task automatic t_commit_pulse(input int base16);
        int width;
        bit done;
        bus_write(4'h5, 8'h00);
        check("R4", "reset raised", console_rst, 1);
        check("R4", "ram bank cleared", ram_bank, 0);
        look(4'h4); check("R4", "rom bank forced 1", flash_bank, (base16 + 1) % 4096);
        width = 1;
        done  = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) begin
            @(negedge clk);
            if (console_rst) width++;
            else done = 1'b1;
        end
        check("R7", "reset pulse width", width, 1024);
    endtask

    task automatic t_locked();
        bus_write(4'h6, 8'h09);
        look(4'h0); check("R6", "base frozen", flash_bank, 48);
        bus_write(4'h5, 8'h03);
        check("R6", "no second reset", console_rst, 0);
        repeat (3) @(negedge clk);
        check("R6", "still no reset", console_rst, 0);
        check("R6", "nibble 5 as ram bank", ram_bank, 3);
        bus_write(4'h4, 8'h1C);
        check("R9", "ram bank locked", ram_bank, 12);
        bus_write(4'h2, 8'hFF);
        look(4'h4); check("R8", "rom 0xFF", flash_bank, 303);
        bus_write(4'h3, 8'h01);
        look(4'h4); check("R8", "rom 0x1FF", flash_bank, 559);
    endtask

    task automatic t_wrap_and_rearm();
        t_reset_state();
        bus_write(4'h6, 8'hFF);
        look(4'h0); check("R10", "max base", flash_bank, 4080);
        bus_write(4'h2, 8'h20);
        look(4'h4); check("R10", "sum wraps", flash_bank, 16);
        look(4'h0);
        t_commit_pulse(4080);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_select_base();
        t_strobe_timing();
        t_ignore_seven();
        t_mbc_select();
        look(4'h0);
        t_commit_pulse(48);
        t_locked();
        t_wrap_and_rearm();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule